// File: doc/BRIEF.md
# Key Input Interrupt Controller

This block watches eight external key lines and turns chosen level changes into interrupt requests for a processor. Every raw line is first brought into the clock domain by a two-stage synchroniser. It then passes through one of two chatter filters: lines 0 to 3 share one filter and lines 4 to 7 share the other. Each filter has its own hold-time setting, counted in ticks of an external prescaler. When a filtered line moves to the level chosen for that bit, the bit's pending flag is set.

The flags are masked by per-bit enables to form a single request. The request carries a two-bit priority level and the exception vector address of the highest-numbered pending and enabled line. Software uses a small register port to set the edge polarity, the enables, the level and the filter times, and to clear flags. The same port holds a bank of pull-up control bits. Each of these bits drives a pad pull-up unless that pad is built as a direct-gate input. On a direct-gate pad the bit remains plain storage.

Top module: `kirq_unit`

## Requirements
- R1: With a filter select code of 0, a level change on a key line reaches the flag logic through the synchroniser without further filtering. The flag bit is set by the fourth rising clock edge after the change.
- R2: The edge-select register is at address 0, with bit i belonging to line i. When this bit is 1, flag i is set on a low-to-high move of the filtered line. When it is 0, flag i is set on a high-to-low move. A move in the other direction does not set the flag.
- R3: The enable register is at address 1. `irq_o` is 1 exactly when some bit is both pending and enabled. A pending flag whose enable is 0 does not raise `irq_o`.
- R4: Bits [1:0] of address 4 hold the priority level. `irq_lvl_o` shows that level from the cycle after the write.
- R5: While `irq_o` is 1, `irq_vec_o` equals 0x000014 − 2·i, where i is the highest-numbered pending enabled line (line 7 → 0x000006, line 0 → 0x000014). While `irq_o` is 0, it is 0.
- R6: Address 2 reads the flags. Writing 1 to a flag bit clears that bit, and writing 0 leaves it unchanged. When a new edge arrives in the same cycle as the clear, the edge wins and the flag stays 1.
- R7: Address 5 holds the select for filter 0 in bits [2:0] (lines 0–3) and the select for filter 1 in bits [6:4] (lines 4–7). A nonzero code n accepts a new level only after it has been stable for 2^n cycles in which `tick_i` is 1. Shorter pulses are dropped, and the two filters act independently.
- R8: The pull-up bits at address 3 reset to 0xFF and can be read and written. `pull_en_o[i]` equals pull-up bit i for ordinary pads and is 0 for pads marked in the `GATE_DIRECT` mask. A marked pad still stores and reads back its bit.
- R9: After reset, the edge-select, enable, flag, level and filter-select registers read 0, `irq_o` is 0 and `irq_vec_o` is 0. Unused addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Prescaler tick that advances the chatter filters |
| key_i | input | 8 | Raw key lines |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| irq_o | output | 1 | Interrupt request |
| irq_lvl_o | output | 2 | Priority level of the request |
| irq_vec_o | output | 24 | Exception vector address of the winning line |
| pull_en_o | output | 8 | Pad pull-up enables |

## Verification
Several properties are checked on every cycle. A flag may only rise after its filtered line has matched the edge-select bit, a clear always takes effect unless an edge is present in the same cycle, and an edge always leaves its flag set. A filter with a nonzero select never changes its output in a cycle without a tick, the vector stays inside the table whenever a request is present, and the level follows each write. Other behaviour needs directed stimulus and can only be shown by the bench scenarios. This covers a glitch shorter than the hold time being dropped, the independence of the two filter groups, the choice of the winning vector when several lines are pending, the pull-up gating of direct-gate pads, and the register reset values.

// File: rtl/kirq_pkg.sv
package kirq_pkg;
  localparam int unsigned KEY_N = 8;
  localparam int unsigned GRP_W = 4;
  localparam int unsigned NGRP  = KEY_N / GRP_W;

  typedef enum logic [2:0] {
    RA_EDGE = 3'd0,
    RA_EN   = 3'd1,
    RA_FLAG = 3'd2,
    RA_PULL = 3'd3,
    RA_PRIO = 3'd4,
    RA_FILT = 3'd5
  } kirq_reg_e;
endpackage

// File: rtl/kirq_sync.sv
module kirq_sync #(
  parameter int unsigned W = 8,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, meta_d, stab_q, stab_d;

    always_comb begin
      meta_d = d_i[b];
      stab_d = meta_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL;
        stab_q <= RST_VAL;
      end else begin
        meta_q <= meta_d;
        stab_q <= stab_d;
      end
    end

    assign q_o[b] = stab_q;
  end
endmodule

// File: rtl/kirq_filter.sv
module kirq_filter #(
  parameter int unsigned W     = 4,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [W-1:0]     din_i,
  output logic [W-1:0]     dout_o
);
  localparam int unsigned CNT_W = (1 << SEL_W);

  logic [W-1:0]     cand_q, cand_d;
  logic [W-1:0]     filt_q, filt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    limit   = CNT_W'(1) << sel_i;
    cnt_inc = cnt_q + CNT_W'(1);
    cand_d  = din_i;
    cnt_d   = cnt_q;
    filt_d  = filt_q;
    if (sel_i == '0) begin
      filt_d = din_i;
      cnt_d  = '0;
    end else if (din_i != cand_q) begin
      cnt_d = '0;
    end else if (filt_q == cand_q) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_inc >= limit) begin
        filt_d = cand_q;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= '1;
      filt_q <= '1;
      cnt_q  <= '0;
    end else begin
      cand_q <= cand_d;
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign dout_o = filt_q;

  // R7: with a nonzero hold time the output only moves on a tick
  p_hold_no_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != '0 && !tick_i) |=> $stable(dout_o));
endmodule

// File: rtl/kirq_unit.sv
module kirq_unit
  import kirq_pkg::*;
#(
  parameter logic [7:0]  GATE_DIRECT = 8'h80,
  parameter int unsigned SEL_W       = 3,
  parameter logic [23:0] VEC_BASE    = 24'h000014,
  parameter int unsigned VEC_STEP    = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic [7:0]  key_i,
  input  logic        wr_i,
  input  logic [2:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        irq_o,
  output logic [1:0]  irq_lvl_o,
  output logic [23:0] irq_vec_o,
  output logic [7:0]  pull_en_o
);
  localparam logic [23:0] VEC_LOW = VEC_BASE - 24'(VEC_STEP * (KEY_N - 1));

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  logic [KEY_N-1:0] key_s, key_f;

  kirq_sync #(.W(KEY_N), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   (key_i),
    .q_o   (key_s)
  );

  logic [SEL_W-1:0] sel_q [NGRP];
  logic [SEL_W-1:0] sel_d [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    kirq_filter #(.W(GRP_W), .SEL_W(SEL_W)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_n),
      .tick_i(tick_i),
      .sel_i (sel_q[g]),
      .din_i (key_s[g*GRP_W +: GRP_W]),
      .dout_o(key_f[g*GRP_W +: GRP_W])
    );
  end

  logic [KEY_N-1:0] cmp_q, cmp_d, en_q, en_d, flag_q, flag_d;
  logic [KEY_N-1:0] pull_q, pull_d, prev_q, prev_d;
  logic [1:0]       prio_q, prio_d;
  logic [KEY_N-1:0] hit, clr, pend;

  // next state for registers and flags
  always_comb begin
    cmp_d  = cmp_q;
    en_d   = en_q;
    pull_d = pull_q;
    prio_d = prio_q;
    for (int g = 0; g < NGRP; g++) sel_d[g] = sel_q[g];
    clr = '0;
    if (wr_i) begin
      case (addr_i)
        RA_EDGE: cmp_d  = wdata_i;
        RA_EN:   en_d   = wdata_i;
        RA_FLAG: clr    = wdata_i;
        RA_PULL: pull_d = wdata_i;
        RA_PRIO: prio_d = wdata_i[1:0];
        RA_FILT: for (int g = 0; g < NGRP; g++) sel_d[g] = wdata_i[4*g +: SEL_W];
        default: ;
      endcase
    end
    hit    = (key_f ^ prev_q) & ~(key_f ^ cmp_q);
    flag_d = (flag_q & ~clr) | hit;
    prev_d = key_f;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      en_q   <= '0;
      flag_q <= '0;
      pull_q <= '1;
      prio_q <= '0;
      prev_q <= '1;
      for (int g = 0; g < NGRP; g++) sel_q[g] <= '0;
    end else begin
      cmp_q  <= cmp_d;
      en_q   <= en_d;
      flag_q <= flag_d;
      pull_q <= pull_d;
      prio_q <= prio_d;
      prev_q <= prev_d;
      for (int g = 0; g < NGRP; g++) sel_q[g] <= sel_d[g];
    end
  end

  // request, level and winning vector
  always_comb begin
    pend      = flag_q & en_q;
    irq_o     = |pend;
    irq_lvl_o = prio_q;
    irq_vec_o = '0;
    for (int i = 0; i < KEY_N; i++) begin
      if (pend[i]) irq_vec_o = VEC_BASE - 24'(VEC_STEP * i);
    end
    pull_en_o = pull_q & ~GATE_DIRECT;
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_EDGE: rdata_o = cmp_q;
      RA_EN:   rdata_o = en_q;
      RA_FLAG: rdata_o = flag_q;
      RA_PULL: rdata_o = pull_q;
      RA_PRIO: rdata_o = {6'b0, prio_q};
      RA_FILT: for (int g = 0; g < NGRP; g++) rdata_o[4*g +: SEL_W] = sel_q[g];
      default: rdata_o = '0;
    endcase
  end

  // R2: a flag only rises when its filtered line matched the edge select
  p_flag_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q) & ~$past(key_f ~^ cmp_q)) == '0));

  // R6: a clear without a same-cycle edge leaves the flag at 0
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((flag_q & $past(clr & ~hit)) == '0));

  // R6: an edge always leaves its flag set, even against a clear
  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((~flag_q & $past(hit)) == '0));

  // R5: the vector stays inside the table while requesting, 0 otherwise
  p_vec_range_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (irq_vec_o <= VEC_BASE && irq_vec_o >= VEC_LOW));
  p_vec_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    !irq_o |-> (irq_vec_o == '0));

  // R4: the level follows the write
  p_level_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_i && addr_i == RA_PRIO) |=> (irq_lvl_o == $past(wdata_i[1:0])));
endmodule

// File: tb/sim_kirq_unit.sv
module sim_kirq_unit;
  logic        clk = 1'b0;
  logic        rst_ni, tick_i, wr_i;
  logic [7:0]  key_i, wdata_i, rdata_o, pull_en_o;
  logic [2:0]  addr_i;
  logic        irq_o;
  logic [1:0]  irq_lvl_o;
  logic [23:0] irq_vec_o;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  kirq_unit #(.GATE_DIRECT(8'h80)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .key_i(key_i),
    .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .irq_lvl_o(irq_lvl_o), .irq_vec_o(irq_vec_o),
    .pull_en_o(pull_en_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(a == 3 ? "R8 pull-up reset" : "R9 register reset", v, a == 3 ? 8'hFF : 8'h00);
    end
    chk("R9 irq idle", irq_o, 0);
    chk("R9 vec idle", irq_vec_o, 0);
    chk("R8 pad pull-up at reset", pull_en_o, 8'h7F);
  endtask

  task automatic t_bypass_fall();
    logic [7:0] v;
    @(negedge clk) key_i[3] = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    addr_i = 3'd2;
    #1 chk("R1 flag after four edges", rdata_o, 8'h08);
    @(negedge clk) key_i[3] = 1'b1;
    idle(6);
    wr(3'd2, 8'hFF);
    rd(3'd2, v);
    chk("R2 rising on falling-select bit ignored", v, 8'h00);
  endtask

  task automatic t_rise_select();
    logic [7:0] v;
    wr(3'd0, 8'h20);
    @(negedge clk) key_i[5] = 1'b0;
    idle(6);
    rd(3'd2, v);
    chk("R2 falling on rising-select bit ignored", v, 8'h00);
    @(negedge clk) key_i[5] = 1'b1;
    idle(6);
    rd(3'd2, v);
    chk("R2 rising select sets flag", v, 8'h20);
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_mask();
    wr(3'd1, 8'h00);
    @(negedge clk) key_i[1] = 1'b0;
    idle(6);
    chk("R3 masked flag no irq", irq_o, 0);
    wr(3'd1, 8'h02);
    #1 chk("R3 enabled flag irq", irq_o, 1);
    chk("R5 vector line 1", irq_vec_o, 24'h000012);
    @(negedge clk) key_i[1] = 1'b1;
    idle(6);
  endtask

  task automatic t_vector();
    wr(3'd1, 8'hFF);
    @(negedge clk) key_i[6] = 1'b0;
    idle(6);
    chk("R5 highest line wins", irq_vec_o, 24'h000008);
    wr(3'd2, 8'h40);
    #1 chk("R5 after clearing line 6", irq_vec_o, 24'h000012);
    wr(3'd2, 8'hFF);
    #1 chk("R3 all cleared no irq", irq_o, 0);
    chk("R5 vector zero when idle", irq_vec_o, 0);
    @(negedge clk) key_i[6] = 1'b1;
    @(negedge clk) key_i[7] = 1'b0; key_i[0] = 1'b0;
    idle(6);
    chk("R5 line 7 vector", irq_vec_o, 24'h000006);
    wr(3'd2, 8'h80);
    #1 chk("R5 line 0 vector", irq_vec_o, 24'h000014);
    @(negedge clk) key_i[7] = 1'b1; key_i[0] = 1'b1;
    idle(6);
    wr(3'd2, 8'hFF);
  endtask

  task automatic t_level();
    wr(3'd4, 8'hFF);
    chk("R4 level 3", irq_lvl_o, 2'd3);
    wr(3'd4, 8'h01);
    chk("R4 level 1", irq_lvl_o, 2'd1);
  endtask

  task automatic t_clear_race();
    logic [7:0] v;
    @(negedge clk) key_i[2] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    wr_i = 1'b1; addr_i = 3'd2; wdata_i = 8'h04;
    @(negedge clk);
    wr_i = 1'b0;
    rd(3'd2, v);
    chk("R6 edge wins over clear", v, 8'h04);
    wr(3'd2, 8'h04);
    rd(3'd2, v);
    chk("R6 write one clears", v, 8'h00);
    @(negedge clk) key_i[2] = 1'b1;
    idle(6);
  endtask

  task automatic t_clear_zero();
    logic [7:0] v;
    @(negedge clk) key_i[3] = 1'b0;
    idle(6);
    wr(3'd2, 8'h00);
    rd(3'd2, v);
    chk("R6 write zero keeps flag", v, 8'h08);
    @(negedge clk) key_i[3] = 1'b1;
    idle(6);
    wr(3'd2, 8'hFF);
  endtask

  task automatic t_debounce();
    logic [7:0] v;
    wr(3'd5, 8'h03);
    rd(3'd5, v);
    chk("R7 select readback", v, 8'h03);
    tick_i = 1'b1;
    @(negedge clk) key_i[0] = 1'b0; key_i[4] = 1'b0;
    idle(3);
    @(negedge clk) key_i[0] = 1'b1; key_i[4] = 1'b1;
    idle(25);
    rd(3'd2, v);
    chk("R7 short pulse dropped, other group bypassed", v, 8'h10);
    wr(3'd2, 8'hFF);
    tick_i = 1'b0;
    @(negedge clk) key_i[0] = 1'b0;
    idle(30);
    rd(3'd2, v);
    chk("R7 no ticks no change", v, 8'h00);
    tick_i = 1'b1;
    idle(20);
    rd(3'd2, v);
    chk("R7 stable level accepted", v, 8'h01);
    @(negedge clk) key_i[0] = 1'b1;
    idle(20);
    wr(3'd2, 8'hFF);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_pullup();
    logic [7:0] v;
    wr(3'd3, 8'h0F);
    rd(3'd3, v);
    chk("R8 pull-up readback", v, 8'h0F);
    chk("R8 pad enables", pull_en_o, 8'h0F);
    wr(3'd3, 8'h80);
    rd(3'd3, v);
    chk("R8 gate pad bit stored", v, 8'h80);
    chk("R8 gate pad not driven", pull_en_o, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; tick_i = 1'b0; key_i = 8'hFF;
    wr_i = 1'b0; addr_i = 3'd0; wdata_i = 8'h00;
    idle(5);
    rst_ni = 1'b1;
    idle(4);
    t_reset();
    t_bypass_fall();
    t_rise_select();
    t_mask();
    t_vector();
    t_level();
    t_clear_race();
    t_clear_zero();
    t_debounce();
    t_pullup();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule